// File: doc/BRIEF.md
# Debug Trigger Chain Combiner

This block turns the raw match results of ten hardware debug triggers into one trap decision per instruction. The triggers are grouped into five fixed pairs, trigger 2i with trigger 2i+1. Each pair is tied to the access sources it watches: pair 0 watches fetch and fetch, pair 1 store and store, pair 2 load and load, pair 3 fetch and store, and pair 4 fetch and load. A pair may be chained. A chained pair fires only when both of its triggers hit together and both name the same trap timing.

Software programs each trigger through a write port. The port carries an index, an enable, a 2-bit match kind, a select bit (1 = compare data, 0 = compare address), a timing bit, an action bit, a chain bit and a 64-bit compare value. Each cycle the pipeline may present a valid instruction with its ten raw hit bits. One cycle later the block reports whether a trap is taken and whether it is taken at the instruction or after it. It also reports which trigger caused the trap, whether the trap came from the fetch side or the memory side, and the action, match kind and compare value of that trigger.

Top module: `trig_chain_combiner`

## Requirements
- R1: After reset every trigger is disabled, every chain is clear and all outputs are 0. A disabled trigger never fires.
- R2: A write with cfgValid=1 and cfgIndex below 10 stores all fields into that trigger. A write with an index of 10 to 15 changes no trigger.
- R3: An enabled trigger in an unchained pair fires whenever its own raw hit bit is 1.
- R4: The chain bit of pair i is taken only from writes to the even index 2i. A chained pair fires only when both triggers are enabled and both raw hits are 1, and the fire is reported as trigger 2i. A single raw hit in a chained pair does not fire.
- R5: A chained pair whose two timing bits differ never fires.
- R6: trapAfter equals the timing bit of the reported trigger: 0 traps at the current instruction, 1 traps after it.
- R7: A pair that holds a load-source trigger (triggers 4, 5 and 9) with select=1 never fires. The blocked pair includes its partner trigger.
- R8: When the store-only pair (triggers 2 and 3) is chained, it never fires.
- R9: When several triggers fire together, trapIndex is the lowest-numbered firing trigger. trapAction, trapKind and trapCompare are that trigger's stored fields.
- R10: fetchTrap is 1 when any fire comes from a fetch-source trigger (0, 1, 6, 8). memTrap is 1 when any fire comes from a memory-source trigger (2, 3, 4, 5, 7, 9). A chained fire counts as a fire of its even trigger. trapOut is the OR of both.
- R11: All outputs are registered. They reflect the instruction presented one cycle earlier, and all are 0 in a cycle that follows no valid instruction.
- R12: flushIn=1 in the same cycle as a valid instruction suppresses that instruction's trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Configuration write strobe |
| cfgIndex | input | 4 | Trigger selected by the write |
| cfgEnable | input | 1 | Trigger enable |
| cfgKind | input | 2 | Match kind, held for the comparators |
| cfgSelect | input | 1 | 1 = data compare, 0 = address compare |
| cfgTiming | input | 1 | 0 = trap at instruction, 1 = trap after it |
| cfgAction | input | 1 | Action taken on the trap |
| cfgChain | input | 1 | Chain the pair (used from even indices only) |
| cfgCompare | input | 64 | Compare value |
| instValid | input | 1 | Instruction present this cycle |
| rawHit | input | 10 | Raw comparator hits, bit t for trigger t |
| flushIn | input | 1 | Drop this cycle's fire |
| trapOut | output | 1 | Trap taken |
| trapAfter | output | 1 | Timing of the reported trigger |
| trapIndex | output | 4 | Reported trigger |
| fetchTrap | output | 1 | A fetch-source trigger fired |
| memTrap | output | 1 | A memory-source trigger fired |
| trapAction | output | 1 | Action of the reported trigger |
| trapKind | output | 2 | Match kind of the reported trigger |
| trapCompare | output | 64 | Compare value of the reported trigger |

## Verification
The bench programs a fixed configuration in which pair 3 is chained with matching timing and pair 4 is chained with mismatched timing. It then walks a table of hit patterns: no hits, single unchained hits of both timings, one half of a chained pair, both halves of each chained pair, mixed fetch and memory hits, and all hits at once. Together these separate the priority order, the pair chaining rule, the timing agreement and the source classification. Directed steps then reconfigure single triggers to cover the blocked pair combinations, out-of-range writes that might alias onto real triggers, disabling a trigger, flush, and cycles without a valid instruction.

// File: rtl/trig_pkg.sv
package trig_pkg;

  localparam int NUM_TRIG = 10;
  localparam int NUM_PAIR = NUM_TRIG / 2;
  localparam int IDX_W    = 4;

  typedef enum logic [1:0] {
    SRC_FETCH = 2'd0,
    SRC_LOAD  = 2'd1,
    SRC_STORE = 2'd2
  } trigSrc_e;

  // Fixed binding of each trigger to the access it watches
  function automatic trigSrc_e srcOf(input int t);
    case (t)
      0, 1, 6, 8: return SRC_FETCH;
      2, 3, 7:    return SRC_STORE;
      default:    return SRC_LOAD;
    endcase
  endfunction

  function automatic logic [NUM_TRIG-1:0] srcMask(input trigSrc_e s);
    logic [NUM_TRIG-1:0] m;
    m = '0;
    for (int t = 0; t < NUM_TRIG; t++) m[t] = (srcOf(t) == s);
    return m;
  endfunction

  typedef struct packed {
    logic       action;
    logic [1:0] kind;
  } trigInfo_t;

  // Strobes from the fire control to the output datapath
  typedef struct packed {
    logic             capture;
    logic             fetchHit;
    logic             memHit;
    logic [IDX_W-1:0] idx;
  } fireStb_t;

endpackage

// File: rtl/trig_cfg_bank.sv
module trig_cfg_bank
  import trig_pkg::*;
#(
  parameter int CMP_W = 64
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgValid,
  input  logic [IDX_W-1:0]         cfgIndex,
  input  logic                     cfgEnable,
  input  logic [1:0]               cfgKind,
  input  logic                     cfgSelect,
  input  logic                     cfgTiming,
  input  logic                     cfgAction,
  input  logic                     cfgChain,
  input  logic [CMP_W-1:0]         cfgCompare,
  output logic [NUM_TRIG-1:0]      enVec,
  output logic [NUM_TRIG-1:0]      selVec,
  output logic [NUM_TRIG-1:0]      timVec,
  output logic [NUM_PAIR-1:0]      pairChain,
  output trigInfo_t                info   [NUM_TRIG],
  output logic [CMP_W-1:0]         cmpArr [NUM_TRIG]
);

  for (genvar t = 0; t < NUM_TRIG; t++) begin : gTrig
    logic wrHit;
    assign wrHit = cfgValid && (cfgIndex == IDX_W'(t));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enVec[t]  <= 1'b0;
        selVec[t] <= 1'b0;
        timVec[t] <= 1'b0;
        info[t]   <= '0;
        cmpArr[t] <= '0;
      end else if (wrHit) begin
        enVec[t]  <= cfgEnable;
        selVec[t] <= cfgSelect;
        timVec[t] <= cfgTiming;
        info[t]   <= '{action: cfgAction, kind: cfgKind};
        cmpArr[t] <= cfgCompare;
      end
    end
  end

  for (genvar p = 0; p < NUM_PAIR; p++) begin : gPair
    always_ff @(posedge clk) begin
      if (!rstN)
        pairChain[p] <= 1'b0;
      else if (cfgValid && (cfgIndex == IDX_W'(2 * p)))
        pairChain[p] <= cfgChain;
    end
  end

  AST_BAD_INDEX_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && (cfgIndex >= IDX_W'(NUM_TRIG))) |=>
      ($stable(enVec) && $stable(selVec) && $stable(timVec) && $stable(pairChain))); // R2

endmodule

// File: rtl/trig_fire_ctrl.sv
module trig_fire_ctrl
  import trig_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                instValid,
  input  logic                flushIn,
  input  logic [NUM_TRIG-1:0] rawHit,
  input  logic [NUM_TRIG-1:0] enVec,
  input  logic [NUM_TRIG-1:0] selVec,
  input  logic [NUM_TRIG-1:0] timVec,
  input  logic [NUM_PAIR-1:0] pairChain,
  output fireStb_t            stb
);

  localparam logic [NUM_TRIG-1:0] FETCH_MASK = srcMask(SRC_FETCH);
  localparam logic [NUM_TRIG-1:0] MEM_MASK   = ~FETCH_MASK;

  logic [NUM_TRIG-1:0] fireVec;

  for (genvar p = 0; p < NUM_PAIR; p++) begin : gPair
    localparam int  A        = 2 * p;
    localparam int  B        = 2 * p + 1;
    localparam bit  A_LOAD   = (srcOf(A) == SRC_LOAD);
    localparam bit  B_LOAD   = (srcOf(B) == SRC_LOAD);
    localparam bit  ST_PAIR  = (srcOf(A) == SRC_STORE) && (srcOf(B) == SRC_STORE);

    logic hitA, hitB, timeEq, blocked;
    assign hitA    = rawHit[A] && enVec[A];
    assign hitB    = rawHit[B] && enVec[B];
    assign timeEq  = (timVec[A] == timVec[B]);
    assign blocked = (A_LOAD && selVec[A]) || (B_LOAD && selVec[B]) ||
                     (ST_PAIR && pairChain[p]);

    assign fireVec[A] = !blocked && (pairChain[p] ? (hitA && hitB && timeEq) : hitA);
    assign fireVec[B] = !blocked && !pairChain[p] && hitB;

    AST_CHAIN_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rstN)
      (pairChain[p] && fireVec[A]) |-> (rawHit[A] && rawHit[B] && enVec[A] && enVec[B])); // R4

    AST_CHAIN_TIMING_MATCH: assert property (@(posedge clk) disable iff (!rstN)
      (pairChain[p] && fireVec[A]) |-> (timVec[A] == timVec[B])); // R5

    if (A_LOAD || B_LOAD) begin : gLoadChk
      AST_LOAD_DATA_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
        ((A_LOAD && selVec[A]) || (B_LOAD && selVec[B])) |-> !(fireVec[A] || fireVec[B])); // R7
    end
  end

  logic             anyFire;
  logic [IDX_W-1:0] lowIdx;

  always_comb begin
    lowIdx = '0;
    for (int t = NUM_TRIG - 1; t >= 0; t--) begin
      if (fireVec[t]) lowIdx = IDX_W'(t);
    end
  end

  assign anyFire = |fireVec;

  always_comb begin
    stb.capture  = instValid && !flushIn && anyFire;
    stb.fetchHit = stb.capture && |(fireVec & FETCH_MASK);
    stb.memHit   = stb.capture && |(fireVec & MEM_MASK);
    stb.idx      = lowIdx;
  end

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |-> (fireVec[stb.idx] &&
      ((fireVec & ((NUM_TRIG'(1) << stb.idx) - NUM_TRIG'(1))) == '0))); // R9

endmodule

// File: rtl/trig_out_stage.sv
module trig_out_stage
  import trig_pkg::*;
#(
  parameter int CMP_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                instValid,
  input  logic                flushIn,
  input  fireStb_t            stb,
  input  logic [NUM_TRIG-1:0] timVec,
  input  trigInfo_t           info   [NUM_TRIG],
  input  logic [CMP_W-1:0]    cmpArr [NUM_TRIG],
  output logic                trapOut,
  output logic                trapAfter,
  output logic [IDX_W-1:0]    trapIndex,
  output logic                fetchTrap,
  output logic                memTrap,
  output logic                trapAction,
  output logic [1:0]          trapKind,
  output logic [CMP_W-1:0]    trapCompare
);

  always_ff @(posedge clk) begin
    if (!rstN || !stb.capture) begin
      trapOut     <= 1'b0;
      trapAfter   <= 1'b0;
      trapIndex   <= '0;
      fetchTrap   <= 1'b0;
      memTrap     <= 1'b0;
      trapAction  <= 1'b0;
      trapKind    <= '0;
      trapCompare <= '0;
    end else begin
      trapOut     <= 1'b1;
      trapAfter   <= timVec[stb.idx];
      trapIndex   <= stb.idx;
      fetchTrap   <= stb.fetchHit;
      memTrap     <= stb.memHit;
      trapAction  <= info[stb.idx].action;
      trapKind    <= info[stb.idx].kind;
      trapCompare <= cmpArr[stb.idx];
    end
  end

  AST_TRAP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    trapOut |-> $past(instValid)); // R11

  AST_FLUSH_SUPPRESS: assert property (@(posedge clk) disable iff (!rstN)
    flushIn |=> !trapOut); // R12

  AST_TRAP_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    trapOut |-> (trapIndex < IDX_W'(NUM_TRIG))); // R9

  AST_SIDE_OR: assert property (@(posedge clk) disable iff (!rstN)
    trapOut |-> (fetchTrap || memTrap)); // R10

endmodule

// File: rtl/trig_chain_combiner.sv
module trig_chain_combiner
  import trig_pkg::*;
#(
  parameter int CMP_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgValid,
  input  logic [IDX_W-1:0]    cfgIndex,
  input  logic                cfgEnable,
  input  logic [1:0]          cfgKind,
  input  logic                cfgSelect,
  input  logic                cfgTiming,
  input  logic                cfgAction,
  input  logic                cfgChain,
  input  logic [CMP_W-1:0]    cfgCompare,
  input  logic                instValid,
  input  logic [NUM_TRIG-1:0] rawHit,
  input  logic                flushIn,
  output logic                trapOut,
  output logic                trapAfter,
  output logic [IDX_W-1:0]    trapIndex,
  output logic                fetchTrap,
  output logic                memTrap,
  output logic                trapAction,
  output logic [1:0]          trapKind,
  output logic [CMP_W-1:0]    trapCompare
);

  logic [NUM_TRIG-1:0] enVec, selVec, timVec;
  logic [NUM_PAIR-1:0] pairChain;
  trigInfo_t           info   [NUM_TRIG];
  logic [CMP_W-1:0]    cmpArr [NUM_TRIG];
  fireStb_t            stb;

  trig_cfg_bank #(.CMP_W(CMP_W)) u_bank (
    .clk(clk), .rstN(rstN),
    .cfgValid(cfgValid), .cfgIndex(cfgIndex), .cfgEnable(cfgEnable),
    .cfgKind(cfgKind), .cfgSelect(cfgSelect), .cfgTiming(cfgTiming),
    .cfgAction(cfgAction), .cfgChain(cfgChain), .cfgCompare(cfgCompare),
    .enVec(enVec), .selVec(selVec), .timVec(timVec), .pairChain(pairChain),
    .info(info), .cmpArr(cmpArr)
  );

  trig_fire_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .instValid(instValid), .flushIn(flushIn), .rawHit(rawHit),
    .enVec(enVec), .selVec(selVec), .timVec(timVec), .pairChain(pairChain),
    .stb(stb)
  );

  trig_out_stage #(.CMP_W(CMP_W)) u_out (
    .clk(clk), .rstN(rstN),
    .instValid(instValid), .flushIn(flushIn), .stb(stb),
    .timVec(timVec), .info(info), .cmpArr(cmpArr),
    .trapOut(trapOut), .trapAfter(trapAfter), .trapIndex(trapIndex),
    .fetchTrap(fetchTrap), .memTrap(memTrap), .trapAction(trapAction),
    .trapKind(trapKind), .trapCompare(trapCompare)
  );

endmodule

// File: tb/trig_chain_combiner_bench.sv
`timescale 1ns/1ps
module trig_chain_combiner_bench;

  localparam int  NT = 10;
  localparam logic [63:0] BASE = 64'hC0DE_0000_0000_0000;
  localparam logic [NT-1:0] TIM = 10'b10_1110_0010;
  localparam logic [NT-1:0] CHN = 10'b01_0100_0000;

  // {rawHit, trap, idx, after, fetch, mem}
  localparam int NV = 13;
  localparam logic [17:0] VEC [NV] = '{
    {10'h000, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0},
    {10'h001, 1'b1, 4'd0, 1'b0, 1'b1, 1'b0},
    {10'h002, 1'b1, 4'd1, 1'b1, 1'b1, 1'b0},
    {10'h00A, 1'b1, 4'd1, 1'b1, 1'b1, 1'b1},
    {10'h020, 1'b1, 4'd5, 1'b1, 1'b0, 1'b1},
    {10'h040, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0},
    {10'h0C0, 1'b1, 4'd6, 1'b1, 1'b1, 1'b0},
    {10'h080, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0},
    {10'h300, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0},
    {10'h100, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0},
    {10'h0D0, 1'b1, 4'd4, 1'b0, 1'b1, 1'b1},
    {10'h3FF, 1'b1, 4'd0, 1'b0, 1'b1, 1'b1},
    {10'h204, 1'b1, 4'd2, 1'b0, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgValid = 1'b0;
  logic [3:0] cfgIndex = '0;
  logic cfgEnable = 1'b0, cfgSelect = 1'b0, cfgTiming = 1'b0, cfgAction = 1'b0, cfgChain = 1'b0;
  logic [1:0] cfgKind = '0;
  logic [63:0] cfgCompare = '0;
  logic instValid = 1'b0, flushIn = 1'b0;
  logic [NT-1:0] rawHit = '0;
  logic trapOut, trapAfter, fetchTrap, memTrap, trapAction;
  logic [3:0] trapIndex;
  logic [1:0] trapKind;
  logic [63:0] trapCompare;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  trig_chain_combiner u_trig_chain_combiner (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgIndex(cfgIndex),
    .cfgEnable(cfgEnable), .cfgKind(cfgKind), .cfgSelect(cfgSelect),
    .cfgTiming(cfgTiming), .cfgAction(cfgAction), .cfgChain(cfgChain),
    .cfgCompare(cfgCompare), .instValid(instValid), .rawHit(rawHit),
    .flushIn(flushIn), .trapOut(trapOut), .trapAfter(trapAfter),
    .trapIndex(trapIndex), .fetchTrap(fetchTrap), .memTrap(memTrap),
    .trapAction(trapAction), .trapKind(trapKind), .trapCompare(trapCompare)
  );

  function automatic logic [74:0] expOut(input logic t, input logic [3:0] i,
                                         input logic a, input logic f, input logic m);
    if (!t) return '0;
    return {1'b1, i, a, f, m, i[0], i[1:0], BASE | 64'(i)};
  endfunction

  function automatic logic [74:0] actOut();
    return {trapOut, trapIndex, trapAfter, fetchTrap, memTrap, trapAction, trapKind, trapCompare};
  endfunction

  task automatic chk(input string tag, input logic [74:0] act, input logic [74:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [3:0] idx, input logic en, input logic sel, input logic ch);
    @(negedge clk);
    cfgValid = 1'b1; cfgIndex = idx; cfgEnable = en; cfgSelect = sel; cfgChain = ch;
    cfgTiming = (idx < 4'd10) ? TIM[idx] : 1'b0;
    cfgAction = idx[0]; cfgKind = idx[1:0]; cfgCompare = BASE | 64'(idx);
    @(negedge clk);
    cfgValid = 1'b0;
  endtask

  task automatic writeStd(input int t);
    cfgWrite(4'(t), 1'b1, 1'b0, CHN[t]);
  endtask

  task automatic runInst(input logic [NT-1:0] hits, input logic v, input logic fl);
    @(negedge clk);
    rawHit = hits; instValid = v; flushIn = fl;
    @(negedge clk);
    instValid = 1'b0; flushIn = 1'b0; rawHit = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    chk("R1 reset outputs", actOut(), '0);
    runInst(10'h3FF, 1'b1, 1'b0);
    chk("R1 disabled triggers after reset", actOut(), '0);

    for (int t = 0; t < NT; t++) writeStd(t);

    for (int n = 0; n < NV; n++) begin
      runInst(VEC[n][17:8], 1'b1, 1'b0);
      chk($sformatf("R3/R4/R5/R6/R9/R10 row %0d", n), actOut(),
          expOut(VEC[n][7], VEC[n][6:3], VEC[n][2], VEC[n][1], VEC[n][0]));
    end

    runInst(10'h3FF, 1'b0, 1'b0);
    chk("R11 no valid instruction", actOut(), '0);
    runInst(10'h3FF, 1'b1, 1'b1);
    chk("R12 flush suppresses", actOut(), '0);
    runInst(10'h001, 1'b1, 1'b0);
    chk("R11 fire after flush", actOut(), expOut(1'b1, 4'd0, 1'b0, 1'b1, 1'b0));

    cfgWrite(4'd10, 1'b0, 1'b0, 1'b0);
    cfgWrite(4'd15, 1'b0, 1'b0, 1'b0);
    runInst(10'h004, 1'b1, 1'b0);
    chk("R2 index 10 ignored", actOut(), expOut(1'b1, 4'd2, 1'b0, 1'b0, 1'b1));
    runInst(10'h0C0, 1'b1, 1'b0);
    chk("R2 index 15 ignored", actOut(), expOut(1'b1, 4'd6, 1'b1, 1'b1, 1'b0));

    cfgWrite(4'd4, 1'b1, 1'b1, 1'b0);
    runInst(10'h010, 1'b1, 1'b0);
    chk("R7 load data trigger blocked", actOut(), '0);
    runInst(10'h020, 1'b1, 1'b0);
    chk("R7 partner of load data blocked", actOut(), '0);
    writeStd(4);
    runInst(10'h020, 1'b1, 1'b0);
    chk("R2 rewrite restores pair 2", actOut(), expOut(1'b1, 4'd5, 1'b1, 1'b0, 1'b1));

    cfgWrite(4'd9, 1'b1, 1'b1, 1'b0);
    runInst(10'h300, 1'b1, 1'b0);
    chk("R7 trigger 9 data blocks pair 4", actOut(), '0);
    writeStd(9);

    cfgWrite(4'd2, 1'b1, 1'b0, 1'b1);
    runInst(10'h00C, 1'b1, 1'b0);
    chk("R8 chained store pair never fires", actOut(), '0);
    writeStd(2);
    runInst(10'h00C, 1'b1, 1'b0);
    chk("R8 unchained store pair fires", actOut(), expOut(1'b1, 4'd2, 1'b0, 1'b0, 1'b1));

    cfgWrite(4'd0, 1'b0, 1'b0, 1'b0);
    runInst(10'h001, 1'b1, 1'b0);
    chk("R3 disabled trigger silent", actOut(), '0);
    runInst(10'h003, 1'b1, 1'b0);
    chk("R3 neighbour still fires", actOut(), expOut(1'b1, 4'd1, 1'b1, 1'b1, 1'b0));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule